// File: doc/BRIEF.md
# Direct-Mapped Write-Through Byte Cache

This block sits between a processor request port and a slower main memory. Processor requests carry a 20-bit byte address, a read/write flag and, for writes, one data byte. Each address is cut into three fields: a tag, a line index and a byte offset. The index selects exactly one of 1024 lines of 8 bytes. The tag stored in that line, together with its valid bit, decides whether the request hits. Block j of memory can only ever live in line j modulo 1024, so a fill simply overwrites whatever that line held before.

A read that hits is answered from the line store without touching memory. A read that misses fetches the whole 8-byte line in one memory transaction, fills the line, and then returns the requested byte. Every write is forwarded to memory as a single byte write. A write that hits also updates the cached byte. A write that misses leaves the cache untouched. Only one processor request is in flight at a time. The requester holds `cpu_req` until `cpu_ready` pulses for one cycle.

The controller has five states. IDLE accepts a request and latches it, moving to LOOKUP. LOOKUP goes to WRITE_OUT for any write, to REPLY for a read hit, and to LINE_FILL for a read miss. LINE_FILL waits for `mem_ready`, then goes to REPLY. WRITE_OUT waits for `mem_ready`, then goes to REPLY. REPLY raises `cpu_ready` for one cycle and returns to IDLE.

Top module: `dm_wt_cache`

## Requirements
- R1: Address bits [2:0] are the byte offset, bits [12:3] the line index and bits [19:13] the tag. A read miss at 0xABCDE therefore fetches the line starting at 0xABCD8 (line 0x39B, offset 6, tag 0x55).
- R2: Reset clears every valid bit, and while reset is held `cpu_ready` and `mem_req` are low. The first read of any address after reset is a miss.
- R3: A read miss issues exactly one memory read (`mem_we`=0) at the line-aligned address. The fetched 64-bit line holds byte k in bits [8k+7:8k]. The read returns the byte at the requested offset.
- R4: A read hit issues no memory request, returns the cached byte, and raises `cpu_ready` in the second cycle after the request is accepted.
- R5: Two addresses with the same index but different tags evict each other. An address with a different index does not disturb a resident line.
- R6: Every write issues exactly one memory write (`mem_we`=1) carrying the full request address and the data byte, whether the write hits or misses.
- R7: A write that hits updates the cached byte, so a later read of that byte returns the new value with no fetch.
- R8: A write that misses allocates no line, so a later read of that address misses.
- R9: `cpu_ready` is high for exactly one cycle per request. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 20 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | 1 = byte write, 0 = line fetch |
| mem_addr | output | 20 | Byte address (line-aligned for fetches) |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 64 | Fetched line, byte k in bits [8k+7:8k] |
| mem_ready | input | 1 | Memory completion |

## Verification
Wrong internal state in this block shows up at the ports on the next request that reaches the damaged line. A lost or spurious valid bit turns a hit into a fetch, or a miss into a silent stale answer. A corrupted tag or index lets two conflicting blocks alias or evict the wrong line, which is visible as an extra or missing memory read. A bad byte update appears as a wrong `cpu_rdata` on the very next read of that byte. The stimulus is therefore arranged so that each fill, conflict, write hit and write miss is followed at once by a read that exposes it, with memory reads and writes counted per request.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_LINE_FILL,
        ST_WRITE_OUT,
        ST_REPLY
    } ctl_state_t;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 3
) (
    input  logic [ADDR_W-1:0]              addr_i,
    output logic [ADDR_W-IDX_W-OFF_W-1:0]  tag_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic [OFF_W-1:0]               off_o
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    // tag | index | offset, most significant first
    assign off_o = addr_i[OFF_W-1:0];
    assign idx_o = addr_i[OFF_W +: IDX_W];
    assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/dmc_byte_pick.sv
module dmc_byte_pick #(
    parameter int LINE_BYTES = 8,
    parameter int OFF_W      = 3
) (
    input  logic [LINE_BYTES*8-1:0] line_i,
    input  logic [OFF_W-1:0]        off_i,
    output logic [7:0]              byte_o
);
    logic [7:0] lane [LINE_BYTES];

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        assign lane[b] = line_i[b*8 +: 8];
    end

    assign byte_o = lane[off_i];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int LINES      = 1024,
    parameter int TAG_W      = 7,
    parameter int LINE_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    // lookup port
    input  logic [$clog2(LINES)-1:0]      look_idx,
    output logic                          look_vld,
    output logic [TAG_W-1:0]              look_tag,
    output logic [LINE_BYTES*8-1:0]       look_line,
    // whole-line fill
    input  logic                          fill_en,
    input  logic [$clog2(LINES)-1:0]      fill_idx,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [LINE_BYTES*8-1:0]       fill_line,
    // single-byte update on a write hit
    input  logic                          poke_en,
    input  logic [$clog2(LINES)-1:0]      poke_idx,
    input  logic [$clog2(LINE_BYTES)-1:0] poke_off,
    input  logic [7:0]                    poke_byte
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int LINE_W = LINE_BYTES * 8;

    logic [LINES-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [LINE_W-1:0] data_mem [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            data_mem[fill_idx] <= fill_line;
            tag_mem[fill_idx]  <= fill_tag;
        end else if (poke_en) begin
            data_mem[poke_idx][{poke_off, 3'b000} +: 8] <= poke_byte;
        end
    end

    assign look_vld  = vld_q[look_idx];
    assign look_tag  = tag_mem[look_idx];
    assign look_line = data_mem[look_idx];

    // R3: a fill leaves the line valid with the fetched tag
    a_r3_fill_sets_line: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_idx)] && (tag_mem[$past(fill_idx)] == $past(fill_tag)));

    logic [IDX_W-1:0] unused_idx_w;
    assign unused_idx_w = '0;
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int LINES      = 1024,
    parameter int LINE_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [7:0]              cpu_wdata,
    output logic                    cpu_ready,
    output logic [7:0]              cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [7:0]              mem_wdata,
    input  logic [LINE_BYTES*8-1:0] mem_rdata,
    input  logic                    mem_ready
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;

    ctl_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [7:0]        wdata_q;
    logic [7:0]        rdata_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;
    logic              line_vld;
    logic [TAG_W-1:0]  line_tag;
    logic [LINE_W-1:0] line_data;
    logic              hit;
    logic [7:0]        hit_byte;
    logic [7:0]        fill_byte;
    logic              fill_en;
    logic              poke_en;

    dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .addr_i (addr_q),
        .tag_o  (req_tag),
        .idx_o  (req_idx),
        .off_o  (req_off)
    );

    dmc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_idx  (req_idx),
        .look_vld  (line_vld),
        .look_tag  (line_tag),
        .look_line (line_data),
        .fill_en   (fill_en),
        .fill_idx  (req_idx),
        .fill_tag  (req_tag),
        .fill_line (mem_rdata),
        .poke_en   (poke_en),
        .poke_idx  (req_idx),
        .poke_off  (req_off),
        .poke_byte (wdata_q)
    );

    dmc_byte_pick #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_pick_hit (
        .line_i (line_data),
        .off_i  (req_off),
        .byte_o (hit_byte)
    );

    dmc_byte_pick #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_pick_fill (
        .line_i (mem_rdata),
        .off_i  (req_off),
        .byte_o (fill_byte)
    );

    assign hit     = line_vld && (line_tag == req_tag);
    assign fill_en = (state_q == ST_LINE_FILL) && mem_ready;
    assign poke_en = (state_q == ST_LOOKUP) && we_q && hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (we_q)      state_d = ST_WRITE_OUT;
                else if (hit)  state_d = ST_REPLY;
                else           state_d = ST_LINE_FILL;
            end
            ST_LINE_FILL: if (mem_ready) state_d = ST_REPLY;
            ST_WRITE_OUT: if (mem_ready) state_d = ST_REPLY;
            ST_REPLY:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // request capture and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && cpu_req) begin
                addr_q  <= cpu_addr;
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
            end
            if (state_q == ST_LOOKUP && !we_q && hit) begin
                rdata_q <= hit_byte;
            end
            if (fill_en) begin
                rdata_q <= fill_byte;
            end
        end
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        unique case (state_q)
            ST_LINE_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            end
            ST_WRITE_OUT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_REPLY:  cpu_ready = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata = rdata_q;
    assign mem_wdata = wdata_q;

    // R9: completion is a single-cycle pulse
    a_r9_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R9: memory request held steady until accepted
    a_r9_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R4: a read hit completes without a memory transaction
    a_r4_hit_skips_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) && !we_q && hit |=> !mem_req && cpu_ready);

    // R8: a write never fills a line
    a_r8_write_never_fills: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !we_q);

    // R6: every write reaches memory as a write
    a_r6_write_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) && we_q |=> mem_req && mem_we);
endmodule

// File: tb/test_dm_wt_cache.sv
`timescale 1ns/1ps
module test_dm_wt_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dm_wt_cache i_dm_wt_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // memory model: pattern plus a small log of written bytes
    logic [19:0] wl_a [16];
    logic [7:0]  wl_d [16];
    int          wl_n = 0;
    int          fetch_cnt = 0;
    int          memw_cnt = 0;
    int          hold_err = 0;
    int          lat = 0;
    logic [19:0] last_fetch = '0;
    logic [19:0] last_waddr = '0;
    logic [7:0]  last_wdata = '0;
    logic [19:0] held_addr = '0;

    function automatic logic [7:0] ref_byte(input logic [19:0] a);
        logic [7:0] v;
        v = a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
        for (int i = 0; i < wl_n; i++) if (wl_a[i] == a) v = wl_d[i];
        return v;
    endfunction

    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_req) begin
            if (lat > 0 && mem_addr != held_addr) hold_err++;
            held_addr = mem_addr;
            if (lat == 2) begin
                lat = 0;
                mem_ready = 1'b1;
                if (mem_we) begin
                    memw_cnt++;
                    last_waddr = mem_addr;
                    last_wdata = mem_wdata;
                    if (wl_n < 16) begin
                        wl_a[wl_n] = mem_addr;
                        wl_d[wl_n] = mem_wdata;
                        wl_n++;
                    end
                end else begin
                    fetch_cnt++;
                    last_fetch = mem_addr;
                    for (int b = 0; b < 8; b++)
                        mem_rdata[b*8 +: 8] = ref_byte({mem_addr[19:3], 3'(b)});
                end
            end else begin
                lat++;
            end
        end else begin
            lat = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic [7:0] rd;
    int         cyc;
    bit         pulse_bad = 0;

    task automatic do_req(input logic we, input logic [19:0] a, input logic [7:0] wd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 300);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        if (cpu_ready) pulse_bad = 1;
    endtask

    // vector: {we, exp_fetch, exp_memw, addr, wdata}
    localparam logic [30:0] VEC [12] = '{
        {1'b0, 1'b1, 1'b0, 20'hABCDE, 8'h00},  // R1 R2 R3 cold miss
        {1'b0, 1'b0, 1'b0, 20'hABCD8, 8'h00},  // R4 hit, offset 0
        {1'b0, 1'b0, 1'b0, 20'hABCDF, 8'h00},  // R4 hit, offset 7
        {1'b1, 1'b0, 1'b1, 20'hABCDB, 8'h5A},  // R6 R7 write hit
        {1'b0, 1'b0, 1'b0, 20'hABCDB, 8'h00},  // R7 read updated byte
        {1'b0, 1'b1, 1'b0, 20'hA9CDE, 8'h00},  // R5 same index, other tag
        {1'b0, 1'b1, 1'b0, 20'hABCDE, 8'h00},  // R5 evicted, misses again
        {1'b0, 1'b1, 1'b0, 20'h12340, 8'h00},  // R3 other index
        {1'b0, 1'b0, 1'b0, 20'hABCDE, 8'h00},  // R5 not disturbed
        {1'b1, 1'b0, 1'b1, 20'h55550, 8'h11},  // R6 write miss
        {1'b0, 1'b1, 1'b0, 20'h55550, 8'h00},  // R8 no allocation
        {1'b0, 1'b0, 1'b0, 20'h12347, 8'h00}   // R4 hit last byte
    };

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check(cpu_ready == 1'b0, "R2", "cpu_ready in reset", 32'(cpu_ready), 0);
        check(mem_req == 1'b0, "R2", "mem_req in reset", 32'(mem_req), 0);
        rst_n = 1'b1;

        for (int v = 0; v < 12; v++) begin
            automatic logic        we   = VEC[v][30];
            automatic logic        efch = VEC[v][29];
            automatic logic        emw  = VEC[v][28];
            automatic logic [19:0] a    = VEC[v][27:8];
            automatic logic [7:0]  wd   = VEC[v][7:0];
            automatic int          f0   = fetch_cnt;
            automatic int          w0   = memw_cnt;
            do_req(we, a, wd);
            check(cyc < 300, "R9", $sformatf("vec%0d completion", v), cyc, 0);
            check((fetch_cnt - f0) == int'(efch), efch ? "R3" : "R4",
                  $sformatf("vec%0d fetch count", v), fetch_cnt - f0, 32'(efch));
            check((memw_cnt - w0) == int'(emw), "R6",
                  $sformatf("vec%0d memory writes", v), memw_cnt - w0, 32'(emw));
            if (we) begin
                check(last_waddr == a && last_wdata == wd, "R6",
                      $sformatf("vec%0d write addr/data", v), {last_waddr, last_wdata}, {a, wd});
            end else begin
                check(rd == ref_byte(a), "R7", $sformatf("vec%0d read byte", v), rd, ref_byte(a));
                if (efch) check(last_fetch == {a[19:3], 3'b000}, "R1",
                                $sformatf("vec%0d fetch address", v), last_fetch, {a[19:3], 3'b000});
                else      check(cyc == 2, "R4", $sformatf("vec%0d hit latency", v), cyc, 2);
            end
        end

        // R1: field split of 0xABCDE seen as line address of the first fetch
        check(VEC[0][27:8] == 20'hABCDE, "R1", "split vector", VEC[0][27:8], 20'hABCDE);

        // R2: reset mid-run drops every line
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(cpu_ready == 1'b0 && mem_req == 1'b0, "R2", "outputs in second reset",
              {cpu_ready, mem_req}, 0);
        rst_n = 1'b1;
        begin
            automatic int f0 = fetch_cnt;
            do_req(1'b0, 20'h12343, 8'h00);
            check(fetch_cnt - f0 == 1, "R2", "miss after reset", fetch_cnt - f0, 1);
            check(rd == ref_byte(20'h12343), "R3", "byte after refill", rd, ref_byte(20'h12343));
        end

        // R9: handshake properties observed over the run
        check(!pulse_bad, "R9", "cpu_ready single cycle", 32'(pulse_bad), 0);
        check(hold_err == 0, "R9", "mem_addr held", hold_err, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule